// File: doc/BRIEF.md
# Event Counter and Watchdog with One Shared Prescaler

This block holds an 8-bit event counter and a watchdog timer that draw on a single power-of-two prescaler. Only one of the two can own the prescaler at a time. A byte-wide mode register sets four things: which side owns the prescaler, the division ratio, whether the counter counts instruction-cycle enables or edges on an external pin, and which pin edge counts. When the counter wraps from its maximum to zero it sets a sticky overflow flag. The flag drives an interrupt line while the interrupt enable is high.

The watchdog advances on a separate slow tick. The clear command restarts it. If it reaches the end of its range, it sends out a one-cycle reset request and drops an active-high "no timeout" status bit. The surrounding core writes the mode register and the counter and issues the clear command. An external reset sequencer takes the reset request.

Top module: `shared_prescale_timer`

## Requirements
- R1: After a synchronous reset, mode_q reads 8'hFF, cnt_q and ovf_flag are 0, wdt_rst is 0 and wdt_ok is 1.
- R2: Mode bit 3 = 0 gives the prescaler to the counter. The counter then advances once per 2^(code+1) counting events, where code is mode bits 2:0 (000 gives 1:2, 111 gives 1:256).
- R3: Mode bit 3 = 1 gives the prescaler to the watchdog. The counter then advances on every counting event, and the watchdog advances once per 2^code slow ticks (000 gives 1:1, 111 gives 1:128).
- R4: Mode bit 5 selects the counting event: 0 for a cycle with cyc_en high, 1 for an edge on ext_pin. Mode bit 4 selects the edge: 0 for low-to-high, 1 for high-to-low. ext_pin passes through two synchronizer flops, so with no prescaling cnt_q changes at the third rising clock edge after the pin changes.
- R5: cnt_we loads cnt_wdata into cnt_q at the next edge. It overrides any count in that cycle and clears the prescaler.
- R6: A count that takes cnt_q from all ones to zero sets ovf_flag. ovf_clr clears the flag, but a wrap in the same cycle wins.
- R7: irq is high exactly when ovf_flag and ovf_ie are both high.
- R8: With wdt_en high, a watchdog advance from its all-ones count makes wdt_rst high for exactly one cycle and sets wdt_ok to 0. The pulse and the status change appear together.
- R9: wdt_clear zeroes the watchdog count and the prescaler and sets wdt_ok to 1. No timeout can occur in that cycle.
- R10: With wdt_en low, the watchdog count is held at zero and wdt_rst never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en | input | 1 | Instruction-cycle enable, one counting event per high cycle |
| ext_pin | input | 1 | Asynchronous external count pin |
| slow_tick | input | 1 | Watchdog tick, one cycle wide |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write data |
| mode_q | output | 8 | Mode register contents |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write data |
| cnt_q | output | CNT_W | Counter value |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ovf_flag | output | 1 | Sticky counter overflow flag |
| irq | output | 1 | Overflow interrupt request |
| wdt_en | input | 1 | Watchdog enable |
| wdt_clear | input | 1 | Watchdog clear command |
| wdt_rst | output | 1 | One-cycle watchdog reset request |
| wdt_ok | output | 1 | High until a watchdog timeout occurs |

## Verification
A prescaler phase that is off by one, or that was not cleared, shows on cnt_q as an advance that comes one event early or late. When the counter owns the prescaler, this is visible within the first ratio's worth of events after a counter write. A watchdog count held in the wrong state is hidden until the timeout point. It then shows as wdt_rst and wdt_ok changing one or more ticks off the expected count. The bench therefore compares every output on every cycle against a reference model. This lets a divergence inside the block be caught at the first cycle where it reaches a port.

// File: rtl/spt_pkg.sv
package spt_pkg;

    localparam int MODE_W     = 8;
    localparam int PRE_STAGES = 8;
    localparam int SEL_W      = $clog2(PRE_STAGES);
    localparam int K_W        = SEL_W + 1;

    typedef enum logic {
        OWN_CNT = 1'b0,
        OWN_WDT = 1'b1
    } pre_owner_e;

    typedef enum logic {
        SRC_CYC = 1'b0,
        SRC_PIN = 1'b1
    } cnt_src_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } pin_edge_e;

    // bit 5 source, bit 4 edge, bit 3 owner, bits 2:0 ratio code
    typedef struct packed {
        logic [MODE_W-SEL_W-4:0] spare;
        cnt_src_e                src;
        pin_edge_e               edge_sel;
        pre_owner_e              owner;
        logic [SEL_W-1:0]        ratio;
    } mode_t;

    // number of prescaler stages in the active path
    function automatic logic [K_W-1:0] stage_count(pre_owner_e o, logic [SEL_W-1:0] code);
        logic [K_W-1:0] k;
        k = {1'b0, code};
        if (o == OWN_CNT) begin
            k = k + 1'b1;
        end
        return k;
    endfunction

    // low k bits set
    function automatic logic [PRE_STAGES-1:0] tap_mask(logic [K_W-1:0] k);
        logic [PRE_STAGES-1:0] m;
        for (int i = 0; i < PRE_STAGES; i++) begin
            m[i] = (i < int'(k));
        end
        return m;
    endfunction

endpackage

// File: rtl/spt_pin_edge.sv
module spt_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic fall_sel,
    output logic pulse
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   level;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign level = sync_q[SYNC_STAGES-1];

    always_comb begin
        if (fall_sel) begin
            pulse = prev_q & ~level;
        end else begin
            pulse = level & ~prev_q;
        end
    end

endmodule

// File: rtl/spt_prescaler.sv
module spt_prescaler
    import spt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  pre_owner_e       owner,
    input  logic [SEL_W-1:0] code,
    output logic             tick
);

    logic [PRE_STAGES-1:0] pre_q;
    logic [PRE_STAGES-1:0] mask;

    assign mask = tap_mask(stage_count(owner, code));
    assign tick = step && ((pre_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_q <= '0;
        end else if (step) begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/spt_watchdog.sv
module spt_watchdog #(
    parameter int WDT_W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    input  logic adv,
    output logic rst_pulse,
    output logic ok
);

    logic [WDT_W-1:0] wcnt_q;
    logic             expire;

    assign expire = en && !clr && adv && (&wcnt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt_q    <= '0;
            rst_pulse <= 1'b0;
            ok        <= 1'b1;
        end else begin
            if (!en || clr) begin
                wcnt_q <= '0;
            end else if (adv) begin
                wcnt_q <= wcnt_q + 1'b1;
            end
            rst_pulse <= expire;
            if (clr) begin
                ok <= 1'b1;
            end else if (expire) begin
                ok <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/shared_prescale_timer.sv
module shared_prescale_timer
    import spt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int WDT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en,
    input  logic              ext_pin,
    input  logic              slow_tick,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic [MODE_W-1:0] mode_q,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [CNT_W-1:0]  cnt_q,
    input  logic              ovf_clr,
    input  logic              ovf_ie,
    output logic              ovf_flag,
    output logic              irq,
    input  logic              wdt_en,
    input  logic              wdt_clear,
    output logic              wdt_rst,
    output logic              wdt_ok
);

    mode_t      mode_r;
    logic       pin_ev;
    logic       cnt_ev;
    logic       pre_step;
    logic       pre_tick;
    logic       cnt_adv;
    logic       wdt_adv;
    logic       wrap;
    logic [CNT_W-1:0] cnt_r;
    logic       ovf_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_r <= mode_t'('1);
        end else if (mode_we) begin
            mode_r <= mode_t'(mode_wdata);
        end
    end

    spt_pin_edge #(
        .SYNC_STAGES(2)
    ) u_edge (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_pin),
        .fall_sel (mode_r.edge_sel == EDGE_FALL),
        .pulse    (pin_ev)
    );

    assign cnt_ev = (mode_r.src == SRC_PIN) ? pin_ev : cyc_en;

    // assignment mux: the owner feeds the prescaler, the other side bypasses it
    always_comb begin
        if (mode_r.owner == OWN_WDT) begin
            pre_step = slow_tick;
            cnt_adv  = cnt_ev;
            wdt_adv  = pre_tick;
        end else begin
            pre_step = cnt_ev;
            cnt_adv  = pre_tick;
            wdt_adv  = slow_tick;
        end
    end

    spt_prescaler u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (wdt_clear || cnt_we),
        .step  (pre_step),
        .owner (mode_r.owner),
        .code  (mode_r.ratio),
        .tick  (pre_tick)
    );

    assign wrap = !cnt_we && cnt_adv && (&cnt_r);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_r <= '0;
            ovf_r <= 1'b0;
        end else begin
            if (cnt_we) begin
                cnt_r <= cnt_wdata;
            end else if (cnt_adv) begin
                cnt_r <= cnt_r + 1'b1;
            end
            if (wrap) begin
                ovf_r <= 1'b1;
            end else if (ovf_clr) begin
                ovf_r <= 1'b0;
            end
        end
    end

    spt_watchdog #(
        .WDT_W(WDT_W)
    ) u_wdt (
        .clk       (clk),
        .rst       (rst),
        .en        (wdt_en),
        .clr       (wdt_clear),
        .adv       (wdt_adv),
        .rst_pulse (wdt_rst),
        .ok        (wdt_ok)
    );

    assign mode_q   = mode_r;
    assign cnt_q    = cnt_r;
    assign ovf_flag = ovf_r;
    assign irq      = ovf_r && ovf_ie;

endmodule

// File: rtl/spt_checker.sv
module spt_checker #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [7:0]       mode_q,
    input logic             cnt_we,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_flag,
    input logic             wdt_en,
    input logic             wdt_clear,
    input logic             wdt_rst,
    input logic             wdt_ok
);

    AST_MODE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> mode_q == 8'hFF); // R1

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !cnt_we |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1)); // R2

    AST_COUNTER_LOAD: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> cnt_q == $past(cnt_wdata)); // R5

    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> cnt_q == '0); // R6

    AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |=> !wdt_rst); // R8

    AST_RST_DROPS_OK: assert property (@(posedge clk) disable iff (rst)
        wdt_rst |-> !wdt_ok); // R8

    AST_CLEAR_SETS_OK: assert property (@(posedge clk) disable iff (rst)
        wdt_clear |=> (wdt_ok && !wdt_rst)); // R9

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !wdt_en |=> !wdt_rst); // R10

endmodule

bind shared_prescale_timer spt_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mode_q    (mode_q),
    .cnt_we    (cnt_we),
    .cnt_wdata (cnt_wdata),
    .cnt_q     (cnt_q),
    .ovf_flag  (ovf_flag),
    .wdt_en    (wdt_en),
    .wdt_clear (wdt_clear),
    .wdt_rst   (wdt_rst),
    .wdt_ok    (wdt_ok)
);

// File: tb/shared_prescale_timer_bench.sv
`timescale 1ns/1ps
module shared_prescale_timer_bench;

    localparam int CW = 8;
    localparam int WW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_en = 0, ext_pin = 0, slow_tick = 0, mode_we = 0;
    logic [7:0] mode_wdata = '0;
    logic [7:0] mode_q;
    logic cnt_we = 0;
    logic [CW-1:0] cnt_wdata = '0;
    logic [CW-1:0] cnt_q;
    logic ovf_clr = 0, ovf_ie = 0, ovf_flag, irq;
    logic wdt_en = 1, wdt_clear = 0, wdt_rst, wdt_ok;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    shared_prescale_timer #(.CNT_W(CW), .WDT_W(WW)) u_shared_prescale_timer (
        .clk(clk), .rst(rst), .cyc_en(cyc_en), .ext_pin(ext_pin), .slow_tick(slow_tick),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .mode_q(mode_q),
        .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_q(cnt_q),
        .ovf_clr(ovf_clr), .ovf_ie(ovf_ie), .ovf_flag(ovf_flag), .irq(irq),
        .wdt_en(wdt_en), .wdt_clear(wdt_clear), .wdt_rst(wdt_rst), .wdt_ok(wdt_ok)
    );

    // reference model
    logic [7:0]    m_mode;
    logic [CW-1:0] m_cnt;
    logic          m_ovf, m_rst, m_ok;
    int            m_pre;
    logic [WW-1:0] m_wdt;
    logic [1:0]    m_sync;
    logic          m_prev;

    function automatic int ratio_of(logic [7:0] md);
        if (md[3]) return 1 << md[2:0];
        return 1 << (md[2:0] + 1);
    endfunction

    always @(posedge clk) begin
        logic ext_ev, ev, pin_in, pout, cadv, wadv, expire, wrap;
        if (rst) begin
            m_mode = 8'hFF; m_cnt = '0; m_ovf = 0; m_rst = 0; m_ok = 1;
            m_pre = 0; m_wdt = '0; m_sync = '0; m_prev = 0;
        end else begin
            ext_ev = m_mode[4] ? (!m_sync[1] && m_prev) : (m_sync[1] && !m_prev);
            ev     = m_mode[5] ? ext_ev : cyc_en;
            pin_in = m_mode[3] ? slow_tick : ev;
            pout   = pin_in && (((m_pre + 1) % ratio_of(m_mode)) == 0);
            cadv   = m_mode[3] ? ev : pout;
            wadv   = m_mode[3] ? pout : slow_tick;
            expire = wdt_en && !wdt_clear && wadv && (m_wdt == '1);
            wrap   = !cnt_we && cadv && (m_cnt == '1);
            m_prev = m_sync[1];
            m_sync = {m_sync[0], ext_pin};
            if (wdt_clear || cnt_we) m_pre = 0;
            else if (pin_in) m_pre = (m_pre + 1) % 256;
            if (cnt_we) m_cnt = cnt_wdata;
            else if (cadv) m_cnt = m_cnt + 1'b1;
            if (wrap) m_ovf = 1;
            else if (ovf_clr) m_ovf = 0;
            if (!wdt_en || wdt_clear) m_wdt = '0;
            else if (wadv) m_wdt = m_wdt + 1'b1;
            m_rst = expire;
            if (wdt_clear) m_ok = 1;
            else if (expire) m_ok = 0;
            if (mode_we) m_mode = mode_wdata;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R1 mode_q", mode_q, m_mode);
        chk("R2 cnt_q", cnt_q, m_cnt);
        chk("R6 ovf_flag", ovf_flag, m_ovf);
        chk("R7 irq", irq, m_ovf && ovf_ie);
        chk("R8 wdt_rst", wdt_rst, m_rst);
        chk("R9 wdt_ok", wdt_ok, m_ok);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        mode_we = 0; cnt_we = 0; ovf_clr = 0; wdt_clear = 0;
    endtask

    task automatic set_mode(logic [7:0] v);
        mode_we = 1; mode_wdata = v; tick();
    endtask

    task automatic load_cnt(logic [CW-1:0] v);
        cnt_we = 1; cnt_wdata = v; tick();
    endtask

    task automatic run_cyc(int n);
        for (int i = 0; i < n; i++) begin
            cyc_en = 1; tick();
        end
        cyc_en = 0;
    endtask

    task automatic run_ticks(int n);
        for (int i = 0; i < n; i++) begin
            slow_tick = 1; tick();
        end
        slow_tick = 0;
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0 (run hung)");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit seen;
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        rst = 1; tick(); tick(); tick();
        rst = 0; tick();
        chk("R1 reset mode", mode_q, 8'hFF);
        chk("R1 reset cnt", cnt_q, 0);
        chk("R1 reset ovf", ovf_flag, 0);
        chk("R1 reset rst", wdt_rst, 0);
        chk("R1 reset ok", wdt_ok, 1);

        // R2: counter owns the prescaler
        set_mode(8'h00); load_cnt(0); run_cyc(10); tick();
        chk("R2 ratio 1:2", cnt_q, 5);
        set_mode(8'h02); load_cnt(0); run_cyc(24); tick();
        chk("R2 ratio 1:8", cnt_q, 3);

        // R3: watchdog owns the prescaler, counter unscaled
        set_mode(8'h08); load_cnt(0); run_cyc(7); tick();
        chk("R3 unscaled count", cnt_q, 7);
        set_mode(8'h09); wdt_clear = 1; tick();
        run_ticks(31);
        chk("R3 wdt 1:2 early", wdt_rst, 0);
        run_ticks(1);
        chk("R3 wdt 1:2 expiry", wdt_rst, 1);

        // R8: timeout pulse with ratio 1:1
        set_mode(8'h08); wdt_clear = 1; tick();
        run_ticks(15);
        chk("R8 no early reset", wdt_rst, 0);
        chk("R8 ok before", wdt_ok, 1);
        run_ticks(1);
        chk("R8 pulse", wdt_rst, 1);
        chk("R8 ok dropped", wdt_ok, 0);
        tick();
        chk("R8 pulse width", wdt_rst, 0);

        // R9: clear restarts the count
        wdt_clear = 1; tick();
        chk("R9 ok restored", wdt_ok, 1);
        run_ticks(10); wdt_clear = 1; tick(); run_ticks(10);
        chk("R9 no reset after clear", wdt_ok, 1);

        // R10: disabled watchdog
        wdt_en = 0; seen = 0;
        for (int i = 0; i < 40; i++) begin
            slow_tick = 1; tick();
            if (wdt_rst) seen = 1;
        end
        slow_tick = 0;
        chk("R10 disabled no reset", seen, 0);
        wdt_en = 1; wdt_clear = 1; tick();

        // R4: pin source, rising then falling
        set_mode(8'h28); load_cnt(0);
        ext_pin = 1; tick(); tick();
        chk("R4 sync latency", cnt_q, 0);
        tick();
        chk("R4 rising counted", cnt_q, 1);
        ext_pin = 0; tick(); tick(); tick(); tick();
        chk("R4 falling ignored", cnt_q, 1);
        run_cyc(5);
        chk("R4 cycle enable ignored", cnt_q, 1);
        set_mode(8'h38);
        ext_pin = 1; tick(); tick(); tick(); tick();
        chk("R4 rising ignored", cnt_q, 1);
        ext_pin = 0; tick(); tick(); tick(); tick();
        chk("R4 falling counted", cnt_q, 2);

        // R5: load overrides count and clears prescaler
        set_mode(8'h00);
        cyc_en = 1; load_cnt(8'hFE);
        chk("R5 load wins", cnt_q, 8'hFE);
        run_cyc(1);
        chk("R5 prescaler cleared", cnt_q, 8'hFE);
        run_cyc(1);
        chk("R5 count resumes", cnt_q, 8'hFF);
        run_cyc(1); load_cnt(8'h10); run_cyc(1);
        chk("R5 mid-phase clear", cnt_q, 8'h10);

        // R6 / R7: overflow and interrupt
        set_mode(8'h08); ovf_ie = 0; load_cnt(8'hFE);
        ovf_clr = 1; tick();
        run_cyc(2);
        chk("R6 wrap value", cnt_q, 0);
        chk("R6 flag set", ovf_flag, 1);
        chk("R7 masked", irq, 0);
        ovf_ie = 1; tick();
        chk("R7 enabled", irq, 1);
        ovf_clr = 1; tick();
        chk("R6 cleared", ovf_flag, 0);
        load_cnt(8'hFF);
        ovf_clr = 1; cyc_en = 1; tick(); cyc_en = 0;
        chk("R6 set wins over clear", ovf_flag, 1);

        // constrained random mix
        for (int i = 0; i < 20000; i++) begin
            cyc_en    = ($urandom % 2) == 0;
            slow_tick = ($urandom % 4) == 0;
            if (($urandom % 10) < 3) ext_pin = ~ext_pin;
            if (($urandom % 50) == 0) begin mode_we = 1; mode_wdata = 8'($urandom); end
            if (($urandom % 100) == 0) begin cnt_we = 1; cnt_wdata = CW'($urandom); end
            ovf_clr   = ($urandom % 20) == 0;
            if (($urandom % 10) == 0) ovf_ie = ~ovf_ie;
            if (($urandom % 200) == 0) wdt_en = ~wdt_en;
            wdt_clear = ($urandom % 100) == 0;
            tick();
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule